// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block places a small direct-mapped data cache between a processor's load/store port and a 32-bit memory bus with a cycle/strobe/acknowledge handshake. Loads to cacheable addresses are answered from the cache when the line is present. When the line is absent, the block raises a miss flag, fetches the single missing word from memory, installs it and then returns it. Loads marked uncacheable bypass the cache entirely and go straight to the bus.

Stores follow a write-through, no-write-allocate policy. Every store becomes a bus write. While that write is in flight, the cache is probed at the store's word address. When the bus acknowledges, the cached copy is overwritten only if that probe hit. A store that misses never creates a line.

The processor side uses 32-bit word addresses. The bus side carries 34-bit byte addresses whose two low bits are always zero, with all four byte lanes selected. An uncached load that is part of a read-modify-write sequence raises a bus lock. The lock stays up until the store that follows has completed. A busy output tells the processor when a new request may be issued.

Top module: `wt_dcache`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) invalidates every line and leaves `busy`, `miss`, `rsp_valid`, `bus_cyc`, `bus_stb`, `bus_we`, `bus_lock`, `bus_sel`, `bus_adr` and `bus_dat_o` all zero. The first cached load after reset therefore misses.
- R2: A store starts a bus write in the cycle after it is accepted. That write drives `bus_cyc`=`bus_stb`=`bus_we`=1, `bus_sel`=4'b1111, `bus_adr`={word address, 2'b00} and `bus_dat_o`=store data. All of these are held unchanged until `bus_ack`.
- R3: On the store's acknowledge, `bus_lock`, `bus_cyc`, `bus_stb`, `bus_we`, `bus_sel`, `bus_adr` and `bus_dat_o` all return to zero, and `busy` falls in the same cycle.
- R4: A store whose address hits writes its data into the line when the acknowledge arrives. A store that misses leaves the cache unchanged, so a later cached load to that address still misses.
- R5: A cached load that hits raises `rsp_valid` with the line's data on the second clock edge after acceptance. It does so without any bus cycle and without asserting `miss`.
- R6: A cached load that misses asserts `miss` and issues exactly one bus read (`bus_we`=0, `bus_sel`=4'b1111, `bus_adr`={word address, 2'b00}). On the acknowledge it installs the data, tag and valid bit, clears `miss`, and returns the bus data on `rsp_valid`.
- R7: A line is indexed by word-address bits [7:0] and tagged by bits [31:8]. A load to the same index with a different tag misses and replaces the line.
- R8: An uncached load issues one bus read with all lanes selected and returns the acknowledged data. It neither reads nor fills the cache, and it never asserts `miss`.
- R9: An uncached load with `req_rmw`=1 raises `bus_lock` together with its bus cycle. The lock stays high until the acknowledge of the next store, which clears it. An uncached load with `req_rmw`=0 leaves `bus_lock` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_uncached | input | 1 | Load bypasses the cache |
| req_rmw | input | 1 | Uncached load belongs to a read-modify-write sequence |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | A request is in progress |
| miss | output | 1 | Cached load missed; refill under way |
| rsp_valid | output | 1 | One-cycle pulse: load data ready |
| rsp_rdata | output | 32 | Load data |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_lock | output | 1 | Bus lock for read-modify-write |
| bus_sel | output | 4 | Byte lane selects |
| bus_adr | output | 34 | Byte address |
| bus_dat_o | output | 32 | Write data to memory |
| bus_ack | input | 1 | Bus acknowledge |
| bus_dat_i | input | 32 | Read data from memory |

## Verification
The bench goes after the store paths, where a write-allocating variant would turn a later load of a never-loaded address into a silent hit, and a design that ignored the probe result would leave stale data behind on a store hit. It aliases two addresses onto one index, so that a missing or shortened tag compare shows up as a wrong hit returning the other address's data. It follows an uncached load with a cached load of the same word, which catches a bypass that fills the cache. It tracks the lock through a read-modify-write load and its closing store, so a lock that is never raised, drops early or outlives the store is reported. A mixed run of loads and stores over a few hundred words is compared against a reference memory and a cache-state model, using a varying number of bus wait states.

// File: rtl/wt_dcache_pkg.sv
// Shared definitions for the write-through data cache.
// Assumes nothing beyond a single clock domain.
package wt_dcache_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for a request
        ST_LOOKUP = 2'd1,   // cached load: tag compare on latched address
        ST_STORE  = 2'd2,   // bus write in flight, cache probed
        ST_LOAD   = 2'd3    // bus read in flight (uncached or refill)
    } dc_state_t;

endpackage

// File: rtl/dc_line_store.sv
// Direct-mapped line storage: one data word, a tag and a valid bit per line.
// Read port is combinational from the index/tag supplied; the write port
// installs data, tag and valid at the clock edge. Valid bits clear on reset.
// Assumes the caller holds the read address stable across a request.
module dc_line_store #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 24,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0]   rd_tag,
    output logic               hit,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid bits: cleared by reset, set by any write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: no reset needed, guarded by valid
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Hit test and read data for the current probe address
    always_comb begin
        hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_data = data_q[rd_idx];
    end

    // R6: a line just written at the probed address is a hit next cycle
    p_fill_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_idx && wr_tag == rd_tag) |=> hit);

    // R1: no line is valid in the cycle after reset releases
    p_reset_invalid_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

endmodule

// File: rtl/dc_ctrl.sv
// Request sequencer and bus master for the write-through cache.
// Accepts one request while idle, runs cache lookup, bus write (store) or bus
// read (uncached load / refill), and drives registered bus outputs.
// Assumes req_valid is only raised while busy is low, and the bus slave
// raises ack for exactly one cycle per transfer.
module dc_ctrl
    import wt_dcache_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 8,
    localparam int TAG_W  = ADDR_W - INDEX_W,
    localparam int SEL_W  = DATA_W / 8,
    localparam int BADR_W = ADDR_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_uncached,
    input  logic               req_rmw,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               miss,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               bus_cyc,
    output logic               bus_stb,
    output logic               bus_we,
    output logic               bus_lock,
    output logic [SEL_W-1:0]   bus_sel,
    output logic [BADR_W-1:0]  bus_adr,
    output logic [DATA_W-1:0]  bus_dat_o,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_dat_i,
    // cache storage interface
    output logic [INDEX_W-1:0] c_idx,
    output logic [TAG_W-1:0]   c_tag,
    input  logic               c_hit,
    input  logic [DATA_W-1:0]  c_rdata,
    output logic               c_wr,
    output logic [DATA_W-1:0]  c_wdata
);
    dc_state_t         state;
    logic [ADDR_W-1:0] lat_addr;

    // Probe address for the storage is always the latched request address
    always_comb begin
        c_idx = lat_addr[INDEX_W-1:0];
        c_tag = lat_addr[ADDR_W-1:INDEX_W];
        busy  = (state != ST_IDLE);
    end

    // Cache write: store hit at acknowledge, or refill data at acknowledge
    always_comb begin
        c_wr    = 1'b0;
        c_wdata = bus_dat_i;
        if (state == ST_STORE && bus_ack && c_hit) begin
            c_wr    = 1'b1;
            c_wdata = bus_dat_o;
        end else if (state == ST_LOAD && bus_ack && miss) begin
            c_wr    = 1'b1;
        end
    end

    // Sequencer and registered bus master
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_addr  <= '0;
            miss      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            bus_cyc   <= 1'b0;
            bus_stb   <= 1'b0;
            bus_we    <= 1'b0;
            bus_lock  <= 1'b0;
            bus_sel   <= '0;
            bus_adr   <= '0;
            bus_dat_o <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_addr <= req_addr;
                        if (req_write) begin
                            bus_cyc   <= 1'b1;
                            bus_stb   <= 1'b1;
                            bus_we    <= 1'b1;
                            bus_sel   <= '1;
                            bus_adr   <= {req_addr, 2'b00};
                            bus_dat_o <= req_wdata;
                            state     <= ST_STORE;
                        end else if (req_uncached) begin
                            bus_cyc  <= 1'b1;
                            bus_stb  <= 1'b1;
                            bus_sel  <= '1;
                            bus_adr  <= {req_addr, 2'b00};
                            if (req_rmw) begin
                                bus_lock <= 1'b1;
                            end
                            state    <= ST_LOAD;
                        end else begin
                            state <= ST_LOOKUP;
                        end
                    end
                end
                ST_LOOKUP: begin
                    if (c_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= c_rdata;
                        state     <= ST_IDLE;
                    end else begin
                        miss    <= 1'b1;
                        bus_cyc <= 1'b1;
                        bus_stb <= 1'b1;
                        bus_sel <= '1;
                        bus_adr <= {lat_addr, 2'b00};
                        state   <= ST_LOAD;
                    end
                end
                ST_STORE: begin
                    if (bus_ack) begin
                        bus_lock  <= 1'b0;
                        bus_cyc   <= 1'b0;
                        bus_stb   <= 1'b0;
                        bus_we    <= 1'b0;
                        bus_sel   <= '0;
                        bus_adr   <= '0;
                        bus_dat_o <= '0;
                        state     <= ST_IDLE;
                    end
                end
                ST_LOAD: begin
                    if (bus_ack) begin
                        bus_cyc   <= 1'b0;
                        bus_stb   <= 1'b0;
                        bus_sel   <= '0;
                        bus_adr   <= '0;
                        miss      <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= bus_dat_i;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: every bus cycle has strobe, all lanes and a word-aligned address
    p_cycle_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_stb && bus_sel == '1 && bus_adr[1:0] == 2'b00));

    // R2: a waiting bus cycle holds its address, data and direction
    p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_adr) &&
                                   $stable(bus_dat_o) && $stable(bus_we)));

    // R3: an acknowledged write leaves the bus fully cleared and idle
    p_store_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && bus_ack) |=> (!bus_cyc && !bus_stb && !bus_we &&
            !bus_lock && bus_sel == '0 && bus_adr == '0 &&
            bus_dat_o == '0 && !busy));

    // R6: an acknowledged refill drops miss and returns data
    p_refill_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && bus_ack) |=> (!miss && rsp_valid));

    // R9: the lock only rises together with a read bus cycle
    p_lock_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> (bus_cyc && !bus_we));

    // R8: miss is never raised by a store
    p_no_miss_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we) |-> !miss);

endmodule

// File: rtl/wt_dcache.sv
// Write-through, no-write-allocate direct-mapped data cache with a single
// bus master port. Wires the sequencer to the line storage.
// Assumes one outstanding request at a time (issue only while busy is low).
module wt_dcache #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 8,
    localparam int TAG_W  = ADDR_W - INDEX_W,
    localparam int SEL_W  = DATA_W / 8,
    localparam int BADR_W = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_uncached,
    input  logic              req_rmw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              miss,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic              bus_lock,
    output logic [SEL_W-1:0]  bus_sel,
    output logic [BADR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_dat_o,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_dat_i
);
    logic [INDEX_W-1:0] c_idx;
    logic [TAG_W-1:0]   c_tag;
    logic               c_hit;
    logic [DATA_W-1:0]  c_rdata;
    logic               c_wr;
    logic [DATA_W-1:0]  c_wdata;

    dc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .INDEX_W(INDEX_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_uncached(req_uncached),
        .req_rmw     (req_rmw),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .miss        (miss),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .bus_cyc     (bus_cyc),
        .bus_stb     (bus_stb),
        .bus_we      (bus_we),
        .bus_lock    (bus_lock),
        .bus_sel     (bus_sel),
        .bus_adr     (bus_adr),
        .bus_dat_o   (bus_dat_o),
        .bus_ack     (bus_ack),
        .bus_dat_i   (bus_dat_i),
        .c_idx       (c_idx),
        .c_tag       (c_tag),
        .c_hit       (c_hit),
        .c_rdata     (c_rdata),
        .c_wr        (c_wr),
        .c_wdata     (c_wdata)
    );

    // Refill and store-hit writes both target the probed line
    dc_line_store #(
        .INDEX_W(INDEX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) i_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (c_idx),
        .rd_tag (c_tag),
        .hit    (c_hit),
        .rd_data(c_rdata),
        .wr_en  (c_wr),
        .wr_idx (c_idx),
        .wr_tag (c_tag),
        .wr_data(c_wdata)
    );

    // R5: a load response never coincides with an open bus cycle
    p_rsp_bus_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!bus_cyc && !busy));

endmodule

// File: tb/test_wt_dcache.sv
// Scoreboard bench: driver tasks push expected load results computed from a
// reference memory and cache-state model; a monitor pops and compares them.
module test_wt_dcache;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_uncached = 1'b0;
    logic          req_rmw = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, miss, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          bus_cyc, bus_stb, bus_we, bus_lock;
    logic [3:0]    bus_sel;
    logic [AW+1:0] bus_adr;
    logic [DW-1:0] bus_dat_o;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_dat_i = '0;

    always #4 clk = ~clk;   // 125 MHz

    wt_dcache i_wt_dcache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_uncached(req_uncached), .req_rmw(req_rmw),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .miss(miss), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_lock(bus_lock), .bus_sel(bus_sel), .bus_adr(bus_adr),
        .bus_dat_o(bus_dat_o), .bus_ack(bus_ack), .bus_dat_i(bus_dat_i)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- memory contents (default pattern) ----------------
    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0] + 16'h1234};
    endfunction

    logic [DW-1:0] slv_mem [logic [AW-1:0]];
    logic [DW-1:0] ref_mem [logic [AW-1:0]];

    function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    // ---------------- bus slave with varying wait states ----------------
    int rd_cnt = 0;
    int xfer_cnt = 0;
    int wcnt = 0;
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_cyc && bus_stb) begin
            if (wcnt >= (xfer_cnt % 3)) begin
                logic [AW-1:0] wa;
                wa = bus_adr[AW+1:2];
                if (bus_we) begin
                    slv_mem[wa] = bus_dat_o;
                end else begin
                    bus_dat_i = slv_mem.exists(wa) ? slv_mem[wa] : init_word(wa);
                    rd_cnt++;
                end
                bus_ack = 1'b1;
                xfer_cnt++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- reference cache-state model ----------------
    bit            m_valid [1<<IW];
    logic [AW-IW-1:0] m_tag [1<<IW];

    function automatic bit m_hit(input logic [AW-1:0] a);
        return m_valid[a[IW-1:0]] && m_tag[a[IW-1:0]] == a[AW-1:IW];
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [DW-1:0] data;
        bit            exp_miss;
        int            exp_reads;
        string         req;
    } item_t;
    item_t sb_q[$];

    bit miss_seen = 0;
    int rd_base = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (miss) miss_seen = 1;
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R5 unexpected response", 64'(rsp_rdata), 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(rsp_rdata == it.data, {it.req, " data"},
                          64'(rsp_rdata), 64'(it.data));
                    check(miss_seen == it.exp_miss, {it.req, " miss flag"},
                          64'(miss_seen), 64'(it.exp_miss));
                    check((rd_cnt - rd_base) == it.exp_reads, {it.req, " bus reads"},
                          64'(rd_cnt - rd_base), 64'(it.exp_reads));
                end
                miss_seen = 0;
                rd_base = rd_cnt;
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_load(input logic [AW-1:0] a, input bit unc, input bit rmw,
                           input string req);
        item_t it;
        wait_idle();
        it.data = ref_rd(a);
        it.req  = req;
        if (unc) begin
            it.exp_miss = 0; it.exp_reads = 1;
        end else if (m_hit(a)) begin
            it.exp_miss = 0; it.exp_reads = 0;
        end else begin
            it.exp_miss = 1; it.exp_reads = 1;
            m_valid[a[IW-1:0]] = 1;
            m_tag[a[IW-1:0]] = a[AW-1:IW];
        end
        sb_q.push_back(it);
        req_valid = 1; req_write = 0; req_uncached = unc; req_rmw = rmw;
        req_addr = a;
        @(negedge clk);
        req_valid = 0; req_uncached = 0; req_rmw = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit exp_lock);
        wait_idle();
        ref_mem[a] = d;     // cached copy, if any, also takes the new data
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check(bus_cyc && bus_stb && bus_we, "R2 store cyc/stb/we",
              64'({bus_cyc, bus_stb, bus_we}), 64'h7);
        check(bus_sel == 4'hF, "R2 store sel", 64'(bus_sel), 64'hF);
        check(bus_adr == {a, 2'b00}, "R2 store byte address",
              64'(bus_adr), 64'({a, 2'b00}));
        check(bus_dat_o == d, "R2 store data", 64'(bus_dat_o), 64'(d));
        check(bus_lock == exp_lock, "R9 lock during store",
              64'(bus_lock), 64'(exp_lock));
        while (busy) @(negedge clk);
        check({bus_cyc, bus_stb, bus_we, bus_lock} == 4'b0 && bus_sel == 0 &&
              bus_adr == 0 && bus_dat_o == 0, "R3 store cleared",
              {bus_adr[31:0], bus_dat_o[27:0], bus_cyc, bus_stb, bus_we, bus_lock}, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < (1<<IW); i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        check(!busy && !miss && !rsp_valid, "R1 reset status",
              64'({busy, miss, rsp_valid}), 0);
        check(!bus_cyc && !bus_stb && !bus_we && !bus_lock && bus_sel == 0 &&
              bus_adr == 0 && bus_dat_o == 0, "R1 reset bus outputs",
              64'({bus_cyc, bus_stb, bus_we, bus_lock, bus_sel}), 0);
        rst_n = 1;

        // R1/R6: first load misses and refills; R5: repeat hits
        do_load(32'h10, 0, 0, "R1/R6 first load after reset");
        do_load(32'h10, 0, 0, "R5 cached hit");
        // R7: same index, different tag
        do_load(32'h110, 0, 0, "R7 alias load misses");
        do_load(32'h10, 0, 0, "R7 original evicted, misses");
        do_load(32'h10, 0, 0, "R5 hit after re-fill");
        // R4: store hit updates the line
        do_store(32'h10, 32'hCAFE_0010, 0);
        do_load(32'h10, 0, 0, "R4 load after store hit");
        // R4: store miss does not allocate
        do_store(32'h20, 32'hBEEF_0020, 0);
        do_load(32'h20, 0, 0, "R4 load after store miss must miss");
        // R8: uncached load does not fill
        do_load(32'h30, 1, 0, "R8 uncached load");
        check(!bus_lock, "R9 no lock on plain uncached load", 64'(bus_lock), 0);
        do_load(32'h30, 0, 0, "R8 cached load after uncached misses");
        do_load(32'h30, 1, 0, "R8 uncached load of cached word uses bus");
        // R9: read-modify-write lock
        do_load(32'h40, 1, 1, "R9 rmw uncached load");
        check(bus_lock, "R9 lock held after rmw load", 64'(bus_lock), 1);
        repeat (3) @(negedge clk);
        check(bus_lock, "R9 lock held while idle", 64'(bus_lock), 1);
        do_store(32'h40, 32'h0000_0041, 1);
        check(!bus_lock, "R9 lock cleared by store", 64'(bus_lock), 0);

        // Mixed traffic against the reference models
        for (int i = 0; i < 120; i++) begin
            logic [AW-1:0] a;
            a = AW'((i * 37) % 600);
            case (i % 4)
                0, 1: do_load(a, 0, 0, "R5/R6/R7 mixed cached load");
                2:    do_store(AW'((i * 53) % 600), 32'h1000_0000 + 32'(i), 0);
                default: do_load(a, 1, 0, "R8 mixed uncached load");
            endcase
        end
        do_load(32'hFFFF_FFFF, 0, 0, "R6 top word address refill");
        do_load(32'hFFFF_FFFF, 0, 0, "R5 top word address hit");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R5 all responses returned", 64'(sb_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end
endmodule